// File: doc/BRIEF.md
# External Bus Interface Controller

This block connects a 16-bit processor core to external memories and peripherals. The core presents one access at a time: address, write data, byte or word size, and direction. The controller sequences the external pins for that access: a full address bus, a 16-bit data bus split into output, output-enable and input, four active-low chip selects with their own enables, an address-latch-enable, and three strobe lines. It returns read data together with a one-cycle acknowledge.

The top two address bits pick one of four regions, and each region has its own chip select. An access reaches its region over either the separate bus or a time-multiplexed bus. On the separate bus, address and data travel on separate pins. On the multiplexed bus, an address phase on the data lines comes before the data phase. Each region can add one wait cycle to its data phase. The three strobe lines follow one of two encodings, selected at run time. One encoding suits a 16-bit wide RAM: read, byte-high-enable and a single write strobe. The other suits byte-wide RAMs: read plus separate high-lane and low-lane write strobes.

Two 8-bit registers set the behaviour, and both are written through a simple register port. The chip-select register is selected with `cfg_sel`=0. The mode register is selected with `cfg_sel`=1. Two inputs describe the system: one says the external bus is 8 bits wide, and one says the device runs in microprocessor mode.

Top module: `ebi_ctrl`

## Requirements
- R1: After reset, the chip-select register holds 0x01, so only `cs_oe[0]` is high and every region inserts a wait cycle. The mode register holds 0, which selects no multiplexed region and the byte-high-enable strobe encoding. While idle, every `cs_n` bit, `rd_n`, `hb_n` and `lb_n` is high, and `ale`, `dat_oe` and `req_ready` are low.
- R2: In the chip-select register, bit i (i = 0..3) is the output enable of chip select i and drives `cs_oe[i]`. When that bit is 0, `cs_n[i]` stays high. When it is 1, `cs_n[i]` is low for the whole access to region i (region = `req_addr[19:18]`).
- R3: In the chip-select register, bit 4+i is the wait bit of region i. A value of 0 makes the data phase two cycles long, and 1 makes it one cycle long. `req_ready` is high only in the last data-phase cycle.
- R4: Mode register bits [1:0] select which accesses use the multiplexed bus: 0 none, 1 region 1 only, 2 region 2 only, 3 all regions. A multiplexed access starts with one address cycle in which `ale` and `dat_oe` are high and all three strobes are high. A separate-bus access has no address cycle.
- R5: While `upu_mode` is high, a multiplexed-select value of 3 acts as 0, and no access uses the multiplexed bus.
- R6: In the address cycle, `dat_o[7:0]` carries address bits 7..0 when `bus8` is high, and address bits 8..1 when it is low. `dat_o[15:8]` is 0.
- R7: When mode register bit 2 is 0, `hb_n` is a byte-high-enable and `lb_n` is the write strobe. During the data phase, `hb_n` is low when the high lane is involved, and `lb_n` is low on writes. A word access involves both lanes. A byte access at an odd address involves the high lane only, and one at an even address the low lane only.
- R8: When mode register bit 2 is 1, `hb_n` and `lb_n` are the high-lane and low-lane write strobes. Each goes low during the data phase of a write that involves its lane, and neither goes low on reads.
- R9: During the data phase, `rd_n` is low exactly on reads, and `dat_oe` is high exactly on writes. Write data on `dat_o` is `req_wdata` for a word, or `req_wdata[7:0]` copied onto both lanes for a byte.
- R10: While `req_ready` is high on a read, `rdata` holds `dat_i` for a word. For a byte it holds the involved lane of `dat_i`, zero-extended.
- R11: Between two accesses there is at least one idle cycle. In it, all chip selects and strobes are high and `dat_oe` is low, so the data bus turns around between a read and a following write.
- R12: `ext_addr` equals the latched request address throughout every cycle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 chip-select register, 1 mode register |
| cfg_wdata | input | 8 | Register write data |
| upu_mode | input | 1 | Microprocessor mode |
| bus8 | input | 1 | External bus is 8 bits wide |
| req_valid | input | 1 | Access request, held until acknowledge |
| req_addr | input | 20 | Byte address |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 word, 0 byte |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Access complete |
| rdata | output | 16 | Read data |
| ext_addr | output | 20 | External address bus |
| dat_o | output | 16 | Data bus output value |
| dat_oe | output | 1 | Data bus output enable |
| dat_i | input | 16 | Data bus input value |
| cs_n | output | 4 | Chip selects, active low |
| cs_oe | output | 4 | Chip-select pin enables |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe |
| hb_n | output | 1 | Byte-high-enable or high-lane write strobe |
| lb_n | output | 1 | Write strobe or low-lane write strobe |

## Verification
The hardest case to reach from the ports is the multiplexed-select value that means all regions while microprocessor mode is on. Only then must address cycles vanish for regions 0 and 3 while regions 1 and 2 keep their separate-bus timing. The bench drives this combination directly, and random register writes, random mode pin toggles and random address, size and direction then land on it again. Read-then-write pairs come out of the random mix often, and each one checks the idle turnaround cycle at the pins.

// File: rtl/ebi_pkg.sv
package ebi_pkg;

    localparam int NUM_CS = 4;
    localparam int CS_W   = $clog2(NUM_CS);
    localparam int DATA_W = 16;
    localparam int BYTE_W = DATA_W / 2;
    localparam int REG_W  = 2 * NUM_CS;

    typedef enum logic [1:0] {
        MX_NONE = 2'd0,
        MX_CS1  = 2'd1,
        MX_CS2  = 2'd2,
        MX_ALL  = 2'd3
    } mux_sel_e;

    typedef enum logic {
        STB_BHE   = 1'b0,
        STB_SPLIT = 1'b1
    } strobe_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_WAIT = 2'd3
    } phase_e;

    typedef struct packed {
        logic [NUM_CS-1:0] wait_n;
        logic [NUM_CS-1:0] en;
    } cs_cfg_t;

    typedef struct packed {
        strobe_mode_e smode;
        mux_sel_e     msel;
    } mode_cfg_t;

    function automatic logic mux_hit(mux_sel_e s, logic [CS_W-1:0] region, logic upu);
        case (s)
            MX_CS1:  return region == CS_W'(1);
            MX_CS2:  return region == CS_W'(2);
            MX_ALL:  return !upu;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ebi_regs.sv
module ebi_regs
    import ebi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    output cs_cfg_t          cs_cfg,
    output mode_cfg_t        mode_cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_cfg         <= '{wait_n: '0, en: NUM_CS'(1)};
            mode_cfg.msel  <= MX_NONE;
            mode_cfg.smode <= STB_BHE;
        end else if (cfg_we) begin
            if (!cfg_sel) begin
                cs_cfg <= cs_cfg_t'(cfg_wdata);
            end else begin
                mode_cfg.msel  <= mux_sel_e'(cfg_wdata[1:0]);
                mode_cfg.smode <= strobe_mode_e'(cfg_wdata[2]);
            end
        end
    end

    // R1: values just after reset
    a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cs_cfg.en == NUM_CS'(1) && cs_cfg.wait_n == '0 &&
                        mode_cfg.msel == MX_NONE && mode_cfg.smode == STB_BHE));

endmodule

// File: rtl/ebi_decode.sv
module ebi_decode
    import ebi_pkg::*;
(
    input  logic            [CS_W-1:0] region,
    input  logic            a0,
    input  logic            word,
    input  cs_cfg_t         cs_cfg,
    input  mode_cfg_t       mode_cfg,
    input  logic            upu_mode,
    output logic            use_mux,
    output logic            use_wait,
    output logic            lane_hi,
    output logic            lane_lo
);

    always_comb begin
        use_mux  = mux_hit(mode_cfg.msel, region, upu_mode);
        use_wait = !cs_cfg.wait_n[region];
        lane_hi  = word || a0;
        lane_lo  = word || !a0;
    end

endmodule

// File: rtl/ebi_seq.sv
module ebi_seq
    import ebi_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_word,
    input  logic              dec_mux,
    input  logic              dec_wait,
    input  logic              dec_hi,
    input  logic              dec_lo,
    input  strobe_mode_e      smode_in,
    output phase_e            phase,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata,
    output logic              acc_write,
    output logic              acc_word,
    output logic              acc_hi,
    output logic              acc_lo,
    output strobe_mode_e      acc_smode,
    output logic              req_ready
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic              word;
        logic              ins_wait;
        logic              hi;
        logic              lo;
        strobe_mode_e      smode;
    } access_t;

    access_t rec;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            rec   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (req_valid) begin
                    rec.addr     <= req_addr;
                    rec.wdata    <= req_wdata;
                    rec.write    <= req_write;
                    rec.word     <= req_word;
                    rec.ins_wait <= dec_wait;
                    rec.hi       <= dec_hi;
                    rec.lo       <= dec_lo;
                    rec.smode    <= smode_in;
                    phase        <= dec_mux ? PH_ADDR : PH_DATA;
                end
                PH_ADDR: phase <= PH_DATA;
                PH_DATA: phase <= rec.ins_wait ? PH_WAIT : PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (phase == PH_DATA && !rec.ins_wait) || phase == PH_WAIT;
        acc_addr  = rec.addr;
        acc_wdata = rec.wdata;
        acc_write = rec.write;
        acc_word  = rec.word;
        acc_hi    = rec.hi;
        acc_lo    = rec.lo;
        acc_smode = rec.smode;
    end

    // R3: a waited data phase lasts one more cycle and acknowledges at its end
    a_r3_wait_stretch: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && !req_ready) |=> (phase == PH_WAIT && req_ready));

    // R4: the address cycle is a single cycle followed by data
    a_r4_addr_single: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ADDR) |=> (phase == PH_DATA && $stable(acc_addr)));

    // R11: an acknowledged access is always followed by an idle cycle
    a_r11_idle_gap: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> (phase == PH_IDLE));

endmodule

// File: rtl/ebi_pins.sv
module ebi_pins
    import ebi_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              acc_write,
    input  logic              acc_word,
    input  logic              acc_hi,
    input  logic              acc_lo,
    input  strobe_mode_e      acc_smode,
    input  logic              bus8,
    input  logic [NUM_CS-1:0] cs_en,
    input  logic [DATA_W-1:0] dat_i,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] dat_o,
    output logic              dat_oe,
    output logic [NUM_CS-1:0] cs_n,
    output logic [NUM_CS-1:0] cs_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              hb_n,
    output logic              lb_n,
    output logic [DATA_W-1:0] rdata
);

    logic              active;
    logic              dphase;
    logic [CS_W-1:0]   region;
    logic [BYTE_W-1:0] mux_byte;

    always_comb begin
        active   = phase != PH_IDLE;
        dphase   = phase == PH_DATA || phase == PH_WAIT;
        region   = acc_addr[ADDR_W-1 -: CS_W];
        mux_byte = bus8 ? acc_addr[BYTE_W-1:0] : acc_addr[BYTE_W:1];
        ext_addr = acc_addr;
        ale      = phase == PH_ADDR;
        cs_oe    = cs_en;
        rd_n     = !(dphase && !acc_write);
        dat_oe   = ale || (dphase && acc_write);

        if (acc_smode == STB_BHE) begin
            hb_n = !(dphase && acc_hi);
            lb_n = !(dphase && acc_write);
        end else begin
            hb_n = !(dphase && acc_write && acc_hi);
            lb_n = !(dphase && acc_write && acc_lo);
        end

        if (ale)
            dat_o = {{BYTE_W{1'b0}}, mux_byte};
        else if (dphase && acc_write)
            dat_o = acc_word ? acc_wdata : {2{acc_wdata[BYTE_W-1:0]}};
        else
            dat_o = '0;

        if (acc_word)
            rdata = dat_i;
        else
            rdata = {{BYTE_W{1'b0}},
                     acc_hi ? dat_i[DATA_W-1:BYTE_W] : dat_i[BYTE_W-1:0]};
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = !(cs_en[i] && active && region == CS_W'(i));

        // R2: a released chip-select pin never goes active
        a_r2_released_idle: assert property (@(posedge clk) disable iff (rst)
            !cs_oe[i] |-> cs_n[i]);
    end

    // R9: the data bus is never driven while the read strobe is active
    a_r9_read_no_drive: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !dat_oe);

    // R11: the data bus is never turned on right after a read strobe
    a_r11_turnaround: assert property (@(posedge clk) disable iff (rst)
        $rose(dat_oe) |-> $past(rd_n));

    // R4: address strobe never overlaps a data strobe
    a_r4_ale_quiet: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && hb_n && lb_n && dat_oe));

endmodule

// File: rtl/ebi_ctrl.sv
module ebi_ctrl
    import ebi_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              upu_mode,
    input  logic              bus8,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] dat_o,
    output logic              dat_oe,
    input  logic [DATA_W-1:0] dat_i,
    output logic [NUM_CS-1:0] cs_n,
    output logic [NUM_CS-1:0] cs_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              hb_n,
    output logic              lb_n
);

    cs_cfg_t           cs_cfg;
    mode_cfg_t         mode_cfg;
    logic              dec_mux, dec_wait, dec_hi, dec_lo;
    phase_e            phase;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wdata;
    logic              acc_write, acc_word, acc_hi, acc_lo;
    strobe_mode_e      acc_smode;

    ebi_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cs_cfg    (cs_cfg),
        .mode_cfg  (mode_cfg)
    );

    ebi_decode u_decode (
        .region   (req_addr[ADDR_W-1 -: CS_W]),
        .a0       (req_addr[0]),
        .word     (req_word),
        .cs_cfg   (cs_cfg),
        .mode_cfg (mode_cfg),
        .upu_mode (upu_mode),
        .use_mux  (dec_mux),
        .use_wait (dec_wait),
        .lane_hi  (dec_hi),
        .lane_lo  (dec_lo)
    );

    ebi_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_write (req_write),
        .req_word  (req_word),
        .dec_mux   (dec_mux),
        .dec_wait  (dec_wait),
        .dec_hi    (dec_hi),
        .dec_lo    (dec_lo),
        .smode_in  (mode_cfg.smode),
        .phase     (phase),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_write (acc_write),
        .acc_word  (acc_word),
        .acc_hi    (acc_hi),
        .acc_lo    (acc_lo),
        .acc_smode (acc_smode),
        .req_ready (req_ready)
    );

    ebi_pins #(.ADDR_W(ADDR_W)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_write (acc_write),
        .acc_word  (acc_word),
        .acc_hi    (acc_hi),
        .acc_lo    (acc_lo),
        .acc_smode (acc_smode),
        .bus8      (bus8),
        .cs_en     (cs_cfg.en),
        .dat_i     (dat_i),
        .ext_addr  (ext_addr),
        .dat_o     (dat_o),
        .dat_oe    (dat_oe),
        .cs_n      (cs_n),
        .cs_oe     (cs_oe),
        .ale       (ale),
        .rd_n      (rd_n),
        .hb_n      (hb_n),
        .lb_n      (lb_n),
        .rdata     (rdata)
    );

    // R5: whole-space multiplexing is refused in microprocessor mode
    a_r5_upu_refuse: assert property (@(posedge clk) disable iff (rst)
        (upu_mode && mode_cfg.msel == MX_ALL && phase == PH_IDLE && req_valid)
        |=> (phase != PH_ADDR));

endmodule

// File: tb/ebi_ctrl_bench.sv
`timescale 1ns/1ps
module ebi_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we, cfg_sel;
    logic [7:0]  cfg_wdata;
    logic        upu_mode, bus8;
    logic        req_valid, req_write, req_word;
    logic [19:0] req_addr;
    logic [15:0] req_wdata;
    logic        req_ready;
    logic [15:0] rdata;
    logic [19:0] ext_addr;
    logic [15:0] dat_o, dat_i;
    logic        dat_oe;
    logic [3:0]  cs_n, cs_oe;
    logic        ale, rd_n, hb_n, lb_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0] sh_cs;
    logic [1:0] sh_msel;
    logic       sh_smode;

    always #2.5 clk = ~clk;

    // external device model: data depends only on the address bus
    function automatic logic [15:0] mem_f(logic [19:0] a);
        return {a[7:0] ^ 8'h3C, a[15:8] ^ 8'h5A};
    endfunction
    assign dat_i = mem_f(ext_addr);

    ebi_ctrl u_ebi_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .upu_mode(upu_mode), .bus8(bus8), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_word(req_word), .req_wdata(req_wdata),
        .req_ready(req_ready), .rdata(rdata), .ext_addr(ext_addr), .dat_o(dat_o),
        .dat_oe(dat_oe), .dat_i(dat_i), .cs_n(cs_n), .cs_oe(cs_oe), .ale(ale),
        .rd_n(rd_n), .hb_n(hb_n), .lb_n(lb_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_mux(logic [1:0] r);
        case (sh_msel)
            2'd1:    return r == 2'd1;
            2'd2:    return r == 2'd2;
            2'd3:    return !upu_mode;
            default: return 1'b0;
        endcase
    endfunction

    task automatic reg_write(input logic sel, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!sel) sh_cs = v;
        else begin sh_msel = v[1:0]; sh_smode = v[2]; end
    endtask

    task automatic access(input logic [19:0] a, input logic wr, input logic wd,
                          input logic [15:0] wv);
        logic [1:0]  r;
        logic        mx, wt, hi, lo, last, is_a;
        int          nph;
        logic [3:0]  ecs;
        logic [15:0] ewd, erd;
        logic [1:0]  estb;
        string       mtag;
        r    = a[19:18];
        mx   = exp_mux(r);
        wt   = !sh_cs[4 + r];
        hi   = wd || a[0];
        lo   = wd || !a[0];
        nph  = (mx ? 1 : 0) + (wt ? 2 : 1);
        ecs  = sh_cs[r] ? ~(4'b1 << r) : 4'hF;
        ewd  = wd ? wv : {2{wv[7:0]}};
        erd  = wd ? mem_f(a) : {8'h00, hi ? mem_f(a)[15:8] : mem_f(a)[7:0]};
        estb = sh_smode ? {!(wr && hi), !(wr && lo)} : {!hi, !wr};
        mtag = (upu_mode && sh_msel == 2'd3) ? "R5" : "R4";
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_word = wd; req_wdata = wv;
        @(posedge clk);
        for (int p = 0; p < nph; p++) begin
            @(negedge clk);
            is_a = mx && (p == 0);
            last = (p == nph - 1);
            chk("R3 ready", req_ready, last);
            chk({mtag, " ale"}, ale, is_a);
            chk("R2 cs_n", cs_n, ecs);
            chk("R12 ext_addr", ext_addr, a);
            if (is_a) begin
                chk("R6 mux addr", dat_o, bus8 ? {8'h00, a[7:0]} : {8'h00, a[8:1]});
                chk("R4 addr oe", {dat_oe, rd_n, hb_n, lb_n}, 4'b1111);
            end else begin
                chk("R9 rd_n", rd_n, wr);
                chk("R9 oe", dat_oe, wr);
                if (wr) chk("R9 wdata", dat_o, ewd);
                chk(sh_smode ? "R8 strobes" : "R7 strobes", {hb_n, lb_n}, estb);
            end
            if (last && !wr) chk("R10 rdata", rdata, erd);
            if (last) req_valid = 1'b0;
        end
        @(negedge clk);
        chk("R11 idle", {cs_n, rd_n, hb_n, lb_n, dat_oe, ale, req_ready},
            {4'hF, 3'b111, 1'b0, 1'b0, 1'b0});
        chk("R2 cs_oe", cs_oe, sh_cs[3:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; upu_mode = 0; bus8 = 0;
        req_valid = 0; req_addr = 0; req_write = 0; req_word = 0; req_wdata = 0;
        sh_cs = 8'h01; sh_msel = 2'd0; sh_smode = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the pins
        chk("R1 cs_oe", cs_oe, 4'b0001);
        chk("R1 idle pins", {cs_n, rd_n, hb_n, lb_n, ale, dat_oe, req_ready},
            {4'hF, 3'b111, 3'b000});
        // R1: default wait, separate bus, byte-high-enable strobes
        access(20'h00124, 1'b0, 1'b1, 16'h0);
        access(20'h00125, 1'b1, 1'b0, 16'h00A7);
        // R2: region with disabled chip select keeps the pin inactive
        access(20'h40010, 1'b0, 1'b0, 16'h0);
        // R5: whole-space mux refused in microprocessor mode
        reg_write(1'b0, 8'hFF);
        reg_write(1'b1, 8'h03);
        upu_mode = 1'b1;
        access(20'hC0301, 1'b0, 1'b0, 16'h0);
        access(20'h40302, 1'b1, 1'b1, 16'h1234);
        upu_mode = 1'b0;
        // R4/R6: whole-space mux on both bus widths
        access(20'hC01FE, 1'b0, 1'b1, 16'h0);
        bus8 = 1'b1;
        access(20'hC01FF, 1'b1, 1'b0, 16'h00C3);
        // R8: split write strobes
        reg_write(1'b1, 8'h06);
        access(20'h80033, 1'b1, 1'b0, 16'h0055);
        access(20'h80034, 1'b1, 1'b0, 16'h0066);
        access(20'h80034, 1'b0, 1'b1, 16'h0);
        // random mix
        for (int k = 0; k < 300; k++) begin
            if (k % 9 == 0) begin
                reg_write(1'b0, 8'($urandom));
                reg_write(1'b1, 8'($urandom));
                upu_mode = 1'($urandom);
                bus8     = 1'($urandom);
            end
            access(20'($urandom), 1'($urandom), 1'($urandom), 16'($urandom));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule